// File: doc/BRIEF.md
# Lockable Region Protection Unit

This block guards a 32-bit address space with a small ordered table of protection entries. Each entry records where its region begins, whether it is active, whether it has been frozen, a 4-bit rights code, a 9-bit memory type and a 5-bit segment tag. A region has no explicit end. It runs from its own start address until the start address of the next entry, so software sorts the table by address to lay out contiguous regions.

Software loads an entry through a single-cycle write port that carries an entry index, an address word and an attribute word. A separate enable register holds one bit per entry and is a second view of the entry enable bits. Setting an entry's lock bit freezes that entry until reset, and also freezes the start address of the entry after it, because that address is where the locked region ends.

Alongside the table, a purely combinational checker takes an address, an access kind and a privilege mode. It returns allow or deny, whether any entry matched, the index of that entry and its memory type.

Top module: `lockable_mpu`

## Requirements
- R1: After reset every entry reads back as all zeros (disabled, unlocked, rights code 0), the enable register reads zero, and every check is denied with `chk_hit`=0.
- R2: A write to an unlocked entry takes effect in the next cycle. The address word holds enable in bit 0, lock in bit 1 and the start address in bits 31:5. The attribute word holds the segment in bits 4:0, the rights code in bits 11:8 and the memory type in bits 20:12. All other bits are discarded on write and read back as zero.
- R3: The rights code is decoded as a whole value, giving (kernel / user) rights as follows. 0: none / none. 1: none / none. 2: execute / none. 3: none / execute. 4: read / none. 5: read+execute / none. 6: read+write / none. 7: read+write+execute / none. 8: write / write. 9: read+write / read+write+execute. 10: read+write / read. 11: read+write+execute / read+execute. 12: read / read. 13: read+execute / read+execute. 14: read+write / read+write. 15: read+write+execute / read+write+execute.
- R4: The access kind `chk_kind` is 00 for read, 01 for write and 10 for execute. The value 11 is always denied. `chk_user`=0 selects kernel mode and 1 selects user mode.
- R5: The matching entry is the highest-indexed enabled entry whose start address (bits 31:5) is at or below `chk_addr[31:5]`. Each region therefore ends just before the next entry's start, with 32-byte granularity.
- R6: When no enabled entry matches, the access is denied and `chk_hit`, `chk_idx` and `chk_mtype` are all zero.
- R7: On a match, `chk_idx` and `chk_mtype` give the matching entry's index and memory type, combinationally from the current table.
- R8: A write to the enable register updates bit 0 of each unlocked entry's address word. An entry write updates that entry's bit in `enb_rdata`. When both happen in the same cycle, the entry write decides that entry's enable bit.
- R9: Once set, a lock bit stays set until reset. A locked entry ignores both entry writes and enable-register writes.
- R10: If entry i-1 is locked, a write to entry i that changes entry i's start address is ignored in full. A write that keeps entry i's start address is accepted.
- R11: `wr_err` is high for exactly the one cycle after a rejected entry write, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 3 | Entry to write |
| wr_addr_word | input | 32 | Start address, lock and enable |
| wr_attr_word | input | 32 | Memory type, rights and segment |
| wr_err | output | 1 | Pulse: previous entry write was rejected |
| enb_wr | input | 1 | Enable register write strobe |
| enb_wdata | input | 8 | New enable bits, one per entry |
| enb_rdata | output | 8 | Current enable bits |
| rd_idx | input | 3 | Entry to read back |
| rd_addr_word | output | 32 | Address word of entry `rd_idx` |
| rd_attr_word | output | 32 | Attribute word of entry `rd_idx` |
| chk_addr | input | 32 | Address to check |
| chk_kind | input | 2 | 00 read, 01 write, 10 execute |
| chk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| chk_allow | output | 1 | Access permitted |
| chk_hit | output | 1 | Some enabled entry matched |
| chk_idx | output | 3 | Index of the matching entry |
| chk_mtype | output | 9 | Memory type of the matching entry |

## Verification
The checker is first tried against a single region that covers all of memory. Every one of the sixteen rights codes is combined with all four access kinds and both privilege modes, which separates read, write and execute rights per mode and shows that the unused code and the invalid kind deny.

Ascending start addresses, probed one below and exactly at each boundary and at the top of memory, show where one region ends and the next begins. An entry placed out of order inside an earlier region shows that the highest index wins, rather than the nearest start address. Addresses below every enabled start give the no-match result.

Lock scenarios compare three cases: a write to the locked entry, a start-changing write to its successor, and a start-preserving write to that successor. This confirms that only the first two are rejected.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int ADDR_W    = 32;
  localparam int START_LSB = 5;
  localparam int START_W   = ADDR_W - START_LSB;
  localparam int RIGHTS_W  = 4;
  localparam int MTYPE_W   = 9;
  localparam int SEG_W     = 5;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_BAD   = 2'b11
  } acc_kind_e;

  // Returns {user r,w,x, kernel r,w,x} for a whole rights code.
  function automatic logic [5:0] rights_perms(input logic [RIGHTS_W-1:0] code);
    logic [5:0] p;
    case (code)
      4'd2:    p = 6'b000_001;
      4'd3:    p = 6'b001_000;
      4'd4:    p = 6'b000_100;
      4'd5:    p = 6'b000_101;
      4'd6:    p = 6'b000_110;
      4'd7:    p = 6'b000_111;
      4'd8:    p = 6'b010_010;
      4'd9:    p = 6'b111_110;
      4'd10:   p = 6'b100_110;
      4'd11:   p = 6'b101_111;
      4'd12:   p = 6'b100_100;
      4'd13:   p = 6'b101_101;
      4'd14:   p = 6'b110_110;
      4'd15:   p = 6'b111_111;
      default: p = 6'b000_000;
    endcase
    return p;
  endfunction

  function automatic logic perm_allows(input logic [2:0] rwx, input acc_kind_e kind);
    case (kind)
      ACC_READ:  return rwx[2];
      ACC_WRITE: return rwx[1];
      ACC_EXEC:  return rwx[0];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic write_blocked(input logic self_lock,
                                         input logic prev_lock,
                                         input logic [START_W-1:0] old_start,
                                         input logic [START_W-1:0] new_start);
    return self_lock || (prev_lock && (old_start != new_start));
  endfunction

endpackage

// File: rtl/mpu_entry_table.sv
module mpu_entry_table
  import mpu_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [ADDR_W-1:0]                  wr_addr_word,
  input  logic [31:0]                        wr_attr_word,
  input  logic                               enb_wr,
  input  logic [N_ENTRIES-1:0]               enb_wdata,
  output logic [N_ENTRIES-1:0][START_W-1:0]  start_q,
  output logic [N_ENTRIES-1:0]               en_q,
  output logic [N_ENTRIES-1:0]               lock_q,
  output logic [N_ENTRIES-1:0][RIGHTS_W-1:0] rights_q,
  output logic [N_ENTRIES-1:0][MTYPE_W-1:0]  mtype_q,
  output logic [N_ENTRIES-1:0][SEG_W-1:0]    seg_q,
  output logic                               wr_reject,
  output logic                               wr_err_q
);

  logic                prev_lock;
  logic                idx_ok;
  logic [START_W-1:0]  new_start;

  assign new_start = wr_addr_word[ADDR_W-1:START_LSB];

  always_comb begin
    idx_ok    = (32'(wr_idx) < N_ENTRIES);
    prev_lock = (wr_idx != '0) ? lock_q[wr_idx - 1'b1] : 1'b0;
    wr_reject = wr_en && (!idx_ok ||
                write_blocked(lock_q[wr_idx], prev_lock, start_q[wr_idx], new_start));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      en_q     <= '0;
      lock_q   <= '0;
      rights_q <= '0;
      mtype_q  <= '0;
      seg_q    <= '0;
      wr_err_q <= 1'b0;
    end else begin
      wr_err_q <= wr_reject;
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (enb_wr && !lock_q[i])
          en_q[i] <= enb_wdata[i];
        if (wr_en && !wr_reject && wr_idx == IDX_W'(i)) begin
          en_q[i]     <= wr_addr_word[0];
          lock_q[i]   <= wr_addr_word[1];
          start_q[i]  <= new_start;
          seg_q[i]    <= wr_attr_word[4:0];
          rights_q[i] <= wr_attr_word[11:8];
          mtype_q[i]  <= wr_attr_word[20:12];
        end
      end
    end
  end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [N_ENTRIES-1:0]              en,
  input  logic [N_ENTRIES-1:0][START_W-1:0] start,
  output logic                              hit,
  output logic [IDX_W-1:0]                  idx
);

  logic [N_ENTRIES-1:0] at_or_above;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign at_or_above[g] = en[g] && (addr[ADDR_W-1:START_LSB] >= start[g]);
  end

  // Later (higher) entries override earlier ones.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (at_or_above[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mpu_rights_check.sv
module mpu_rights_check
  import mpu_pkg::*;
(
  input  logic                hit,
  input  logic [RIGHTS_W-1:0] code,
  input  logic [1:0]          kind,
  input  logic                user,
  output logic                allow
);

  logic [5:0] perms;
  logic [2:0] mode_rwx;

  always_comb begin
    perms    = rights_perms(code);
    mode_rwx = user ? perms[5:3] : perms[2:0];
    allow    = hit && perm_allows(mode_rwx, acc_kind_e'(kind));
  end

endmodule

// File: rtl/lockable_mpu.sv
module lockable_mpu
  import mpu_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [31:0]          wr_addr_word,
  input  logic [31:0]          wr_attr_word,
  output logic                 wr_err,
  input  logic                 enb_wr,
  input  logic [N_ENTRIES-1:0] enb_wdata,
  output logic [N_ENTRIES-1:0] enb_rdata,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [31:0]          rd_addr_word,
  output logic [31:0]          rd_attr_word,
  input  logic [31:0]          chk_addr,
  input  logic [1:0]           chk_kind,
  input  logic                 chk_user,
  output logic                 chk_allow,
  output logic                 chk_hit,
  output logic [IDX_W-1:0]     chk_idx,
  output logic [8:0]           chk_mtype
);

  logic [N_ENTRIES-1:0][START_W-1:0]  start_q;
  logic [N_ENTRIES-1:0]               en_q;
  logic [N_ENTRIES-1:0]               lock_q;
  logic [N_ENTRIES-1:0][RIGHTS_W-1:0] rights_q;
  logic [N_ENTRIES-1:0][MTYPE_W-1:0]  mtype_q;
  logic [N_ENTRIES-1:0][SEG_W-1:0]    seg_q;
  logic                               wr_reject;
  logic                               match_hit;
  logic [IDX_W-1:0]                   match_idx;

  mpu_entry_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_addr_word (wr_addr_word),
    .wr_attr_word (wr_attr_word),
    .enb_wr       (enb_wr),
    .enb_wdata    (enb_wdata),
    .start_q      (start_q),
    .en_q         (en_q),
    .lock_q       (lock_q),
    .rights_q     (rights_q),
    .mtype_q      (mtype_q),
    .seg_q        (seg_q),
    .wr_reject    (wr_reject),
    .wr_err_q     (wr_err)
  );

  mpu_region_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .addr  (chk_addr),
    .en    (en_q),
    .start (start_q),
    .hit   (match_hit),
    .idx   (match_idx)
  );

  mpu_rights_check u_rights (
    .hit   (match_hit),
    .code  (rights_q[match_idx]),
    .kind  (chk_kind),
    .user  (chk_user),
    .allow (chk_allow)
  );

  assign chk_hit   = match_hit;
  assign chk_idx   = match_idx;
  assign chk_mtype = match_hit ? mtype_q[match_idx] : '0;

  assign enb_rdata    = en_q;
  assign rd_addr_word = {start_q[rd_idx], 3'b000, lock_q[rd_idx], en_q[rd_idx]};
  assign rd_attr_word = {11'd0, mtype_q[rd_idx], rights_q[rd_idx], 3'b000, seg_q[rd_idx]};

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
  import mpu_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               wr_en,
  input logic                               wr_reject,
  input logic                               wr_err,
  input logic [N_ENTRIES-1:0]               lock_q,
  input logic [N_ENTRIES-1:0]               en_q,
  input logic [N_ENTRIES-1:0][START_W-1:0]  start_q,
  input logic [N_ENTRIES-1:0][RIGHTS_W-1:0] rights_q,
  input logic [N_ENTRIES-1:0][MTYPE_W-1:0]  mtype_q,
  input logic [1:0]                         chk_kind,
  input logic                               chk_allow,
  input logic                               chk_hit,
  input logic [31:0]                        rd_attr_word,
  input logic [31:0]                        rd_addr_word
);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_q) & lock_q) == $past(lock_q)));

  assert_err_after_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));

  assert_reject_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> wr_en);

  assert_allow_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_allow |-> chk_hit);

  assert_bad_kind_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_kind == 2'b11) |-> !chk_allow);

  assert_mbz_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_attr_word[7:5] == 3'b000) && (rd_attr_word[31:21] == 11'd0) &&
    (rd_addr_word[4:2] == 3'b000));

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_frozen
    assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_q[g]) |-> ($stable(start_q[g]) && $stable(en_q[g]) &&
                            $stable(rights_q[g]) && $stable(mtype_q[g])));
    if (g > 0) begin : g_next
      assert_next_start_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q[g-1]) |-> $stable(start_q[g]));
    end
  end

endmodule

bind lockable_mpu mpu_checker #(.N_ENTRIES(N_ENTRIES)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_reject    (wr_reject),
  .wr_err       (wr_err),
  .lock_q       (lock_q),
  .en_q         (en_q),
  .start_q      (start_q),
  .rights_q     (rights_q),
  .mtype_q      (mtype_q),
  .chk_kind     (chk_kind),
  .chk_allow    (chk_allow),
  .chk_hit      (chk_hit),
  .rd_attr_word (rd_attr_word),
  .rd_addr_word (rd_addr_word)
);

// File: tb/lockable_mpu_bench.sv
`timescale 1ns/1ps
module lockable_mpu_bench;

  localparam int N = 8;

  // Rights per code, one bit per code value (bit c = code c grants it).
  localparam logic [15:0] K_RD = 16'hFEF0;
  localparam logic [15:0] K_WR = 16'hCFC0;
  localparam logic [15:0] K_EX = 16'hA8A4;
  localparam logic [15:0] U_RD = 16'hFE00;
  localparam logic [15:0] U_WR = 16'hC300;
  localparam logic [15:0] U_EX = 16'hAA08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [31:0] wr_addr_word = '0, wr_attr_word = '0;
  logic wr_err;
  logic enb_wr = 1'b0;
  logic [N-1:0] enb_wdata = '0, enb_rdata;
  logic [2:0] rd_idx = '0;
  logic [31:0] rd_addr_word, rd_attr_word;
  logic [31:0] chk_addr = '0;
  logic [1:0] chk_kind = '0;
  logic chk_user = 1'b0;
  logic chk_allow, chk_hit;
  logic [2:0] chk_idx;
  logic [8:0] chk_mtype;

  int n_cmp = 0, n_bad = 0;

  // Bench-side model of the table
  logic [26:0] m_start [N];
  logic        m_en    [N];
  logic        m_lock  [N];
  logic [3:0]  m_rights[N];
  logic [8:0]  m_mt    [N];
  logic [4:0]  m_seg   [N];

  always #2 clk = ~clk;

  lockable_mpu u_lockable_mpu (.*);

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_allow(int code, int kind, bit user);
    logic [15:0] m;
    case (kind)
      0: m = user ? U_RD : K_RD;
      1: m = user ? U_WR : K_WR;
      2: m = user ? U_EX : K_EX;
      default: return 1'b0;
    endcase
    return m[code];
  endfunction

  function automatic int ref_find(logic [31:0] a);
    for (int i = N - 1; i >= 0; i--)
      if (m_en[i] && a >= {m_start[i], 5'b0}) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_start[i] = '0; m_en[i] = 0; m_lock[i] = 0;
      m_rights[i] = '0; m_mt[i] = '0; m_seg[i] = '0;
    end
  endtask

  task automatic write_entry(string req, int idx, logic [31:0] aw, logic [31:0] tw);
    bit rej;
    rej = m_lock[idx] || (idx > 0 && m_lock[idx-1] && aw[31:5] != m_start[idx]);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_addr_word = aw; wr_attr_word = tw;
    @(negedge clk);
    wr_en = 1'b0;
    check_eq(req, "wr_err", 32'(wr_err), 32'(rej));
    if (!rej) begin
      m_en[idx] = aw[0]; m_lock[idx] = aw[1]; m_start[idx] = aw[31:5];
      m_seg[idx] = tw[4:0]; m_rights[idx] = tw[11:8]; m_mt[idx] = tw[20:12];
    end
  endtask

  task automatic write_enb(logic [N-1:0] v);
    @(negedge clk);
    enb_wr = 1'b1; enb_wdata = v;
    @(negedge clk);
    enb_wr = 1'b0;
    for (int i = 0; i < N; i++) if (!m_lock[i]) m_en[i] = v[i];
  endtask

  task automatic check_entry(string req, int idx);
    rd_idx = 3'(idx);
    #1;
    check_eq(req, "rd_addr_word", rd_addr_word,
             {m_start[idx], 3'b000, m_lock[idx], m_en[idx]});
    check_eq(req, "rd_attr_word", rd_attr_word,
             {11'd0, m_mt[idx], m_rights[idx], 3'b000, m_seg[idx]});
  endtask

  task automatic check_access(string req, logic [31:0] a, int kind, bit user);
    int f;
    @(negedge clk);
    chk_addr = a; chk_kind = 2'(kind); chk_user = user;
    #1;
    f = ref_find(a);
    if (f < 0) begin
      check_eq(req, "hit", 32'(chk_hit), 0);
      check_eq(req, "allow", 32'(chk_allow), 0);
      check_eq(req, "idx", 32'(chk_idx), 0);
      check_eq(req, "mtype", 32'(chk_mtype), 0);
    end else begin
      check_eq(req, "hit", 32'(chk_hit), 1);
      check_eq(req, "idx", 32'(chk_idx), 32'(f));
      check_eq(req, "mtype", 32'(chk_mtype), 32'(m_mt[f]));
      check_eq(req, "allow", 32'(chk_allow), 32'(ref_allow(int'(m_rights[f]), kind, user)));
    end
  endtask

  task automatic t_reset();  // R1
    for (int i = 0; i < N; i++) check_entry("R1", i);
    check_eq("R1", "enb_rdata", 32'(enb_rdata), 0);
    check_access("R1", 32'h0000_0000, 0, 0);
    check_access("R1", 32'hFFFF_FFE0, 2, 1);
  endtask

  task automatic t_rights_sweep();  // R3, R4
    for (int c = 0; c < 16; c++) begin
      write_entry("R3", 0, 32'h0000_0001, 32'(c) << 8);
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++)
          check_access(k == 3 ? "R4" : "R3", 32'h1234_5678, k, u[0]);
    end
  endtask

  task automatic t_fields();  // R2
    write_entry("R2", 5, 32'hABCD_E01D, 32'hFFFF_FFFF);
    check_entry("R2", 5);
    check_eq("R2", "raw addr word", rd_addr_word, 32'hABCD_E001);
    check_eq("R2", "raw attr word", rd_attr_word, 32'h001F_FF1F);
    write_entry("R2", 5, 32'h0000_0000, 32'h0000_0000);
    check_entry("R2", 5);
  endtask

  task automatic t_regions();  // R5, R7
    write_entry("R5", 0, 32'h0000_0001, 32'h0001_1E00);
    write_entry("R5", 1, 32'h0000_0101, 32'h0002_2C01);
    write_entry("R5", 2, 32'h0000_0201, 32'h0003_3602);
    write_entry("R5", 3, 32'h0000_0401, 32'h0004_4D03);
    check_access("R5", 32'h0000_00FF, 0, 0);
    check_access("R5", 32'h0000_0100, 0, 1);
    check_access("R5", 32'h0000_01FF, 1, 1);
    check_access("R5", 32'h0000_0200, 1, 0);
    check_access("R5", 32'h0000_03FF, 2, 0);
    check_access("R5", 32'h0000_0400, 2, 1);
    check_access("R7", 32'hFFFF_FFFF, 0, 1);
    // out-of-order entry inside region 1: highest index wins
    write_entry("R5", 4, 32'h0000_0181, 32'h0005_5F04);
    check_access("R5", 32'h0000_01A0, 2, 1);
    check_access("R5", 32'h0000_0250, 1, 1);
    check_access("R7", 32'h0000_0180, 0, 0);
    write_entry("R5", 4, 32'h0000_0180, 32'h0005_5F04);
    check_access("R7", 32'h0000_0250, 1, 1);
  endtask

  task automatic t_no_match_and_mirror();  // R6, R8
    write_enb(8'b0000_1000);
    check_eq("R8", "enb_rdata", 32'(enb_rdata), 32'h08);
    check_entry("R8", 0);
    check_entry("R8", 3);
    check_access("R6", 32'h0000_0100, 0, 0);
    check_access("R6", 32'h0000_03FF, 1, 1);
    check_access("R6", 32'h0000_0400, 1, 1);
    write_entry("R8", 6, 32'h0000_0801, 32'h0000_0F00);
    check_eq("R8", "enb_rdata after entry write", 32'(enb_rdata), 32'h48);
    // same cycle: entry write to 6 clears it, enable write sets all
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_addr_word = 32'h0000_0800; wr_attr_word = 32'h0000_0F00;
    enb_wr = 1'b1; enb_wdata = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0; enb_wr = 1'b0;
    for (int i = 0; i < N; i++) m_en[i] = (i != 6);
    check_eq("R8", "enb_rdata same cycle", 32'(enb_rdata), 32'hBF);
    check_entry("R8", 6);
  endtask

  task automatic t_lock();  // R9, R10, R11
    write_entry("R9", 2, 32'h0000_0203, 32'h0003_3600);
    check_entry("R9", 2);
    @(negedge clk);
    check_eq("R11", "wr_err idle", 32'(wr_err), 0);
    write_entry("R9", 2, 32'h0000_0200, 32'h0000_0F00);
    check_entry("R9", 2);
    @(negedge clk);
    check_eq("R11", "wr_err one cycle", 32'(wr_err), 0);
    write_enb(8'h00);
    check_eq("R9", "locked enable kept", 32'(enb_rdata[2]), 1);
    check_entry("R9", 2);
    write_entry("R10", 3, 32'h0000_0601, 32'h0000_0F00);
    check_entry("R10", 3);
    write_entry("R10", 3, 32'h0000_0401, 32'h0000_0F00);
    check_entry("R10", 3);
    write_entry("R10", 1, 32'h0000_0081, 32'h0000_0C00);
    check_entry("R10", 1);
    check_access("R9", 32'h0000_0300, 1, 0);
    check_access("R9", 32'h0000_0300, 1, 1);
  endtask

  initial begin
    #(4.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rights_sweep();
    t_fields();
    t_regions();
    t_no_match_and_mirror();
    t_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule